// File: doc/BRIEF.md
# Pointer-Addressed Delay Line

This block delays a stream of data words by a fixed number of clock cycles. It keeps the samples in an inferred synchronous memory rather than in a cascade of registers. A stored word is never moved. A write address and a read address step through the array together, and the read address stays one entry ahead of the write address. A word therefore waits in its entry until the read address comes round to it. Seen from the pins, the block acts like a chain of `DEPTH` registers that all advance on the same enable.

When `en` is low the line holds: neither address moves, nothing is written and the output register keeps its value, so no sample is lost. A `valid` flag rises once the line has taken in enough samples that its output carries real data. Synchronous reset brings the addresses back to their start positions and clears the output and the flag. The memory array itself is not cleared.

Top module: `ring_delay_line`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `dout` is cleared to 0 and `valid` to 0. Both keep those values until the first enabled edge after reset.
- R2: Count the enabled edges (rising edges with `en` high) after reset as 1, 2, 3, .... After the k-th of them, with k at least `DEPTH`, `dout` equals the `din` that was sampled at enabled edge k-`DEPTH`+1.
- R3: An edge with `en` low changes neither `dout` nor `valid`. The enabled edges that follow keep to the R2 relation, with no sample dropped or repeated.
- R4: `valid` stays 0 through the first `DEPTH`-1 enabled edges after reset. It becomes 1 on the `DEPTH`-th enabled edge and stays 1 until the next reset.
- R5: The read address starts at entry 0 and the write address at entry `DEPTH`-1. Each enabled edge moves both forward by one, and the step after entry `DEPTH`-1 goes to entry 0. The read address is always the entry after the write address, so the two never point at the same entry. The stream stays correct over many passes round the array.
- R6: A reset in the middle of a stream discards the history. `valid` drops, and filling starts again from zero, as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance: write `din`, move both addresses, update `dout` |
| din | input | WIDTH | Sample entering the line |
| dout | output | WIDTH | Sample leaving the line, from the output register of the array |
| valid | output | 1 | High once `DEPTH` samples have entered since reset |

## Verification
The bench builds the line with `DEPTH` = 5 and `WIDTH` = 8. A short line brings the address wrap and the full condition within a few cycles. Over one stimulus table and one long run, both addresses go round the array many times, and stalls fall before the line is full, just as it fills, and after it is full. A mid-stream reset followed by a refill checks the exact edge on which `valid` rises a second time.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  // Next entry in a ring of 'depth' entries: step by one, return to 0 after the last.
  function automatic logic [31:0] ring_next(input logic [31:0] cur, input int unsigned depth);
    if (cur == 32'(depth - 1)) return 32'd0;
    return cur + 32'd1;
  endfunction

  // Fill counter: goes up by one per enabled edge and stops at 'depth'.
  function automatic logic [31:0] fill_next(input logic [31:0] cnt, input int unsigned depth);
    if (cnt >= 32'(depth)) return 32'(depth);
    return cnt + 32'd1;
  endfunction

endpackage

// File: rtl/rdl_ptr.sv
module rdl_ptr #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int START = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  import rdl_pkg::*;

  logic [AW-1:0] addr_nxt;

  always_comb addr_nxt = AW'(ring_next(32'(addr), DEPTH));

  always_ff @(posedge clk) begin
    if (rst)      addr <= AW'(START);
    else if (adv) addr <= addr_nxt;
  end
endmodule

// File: rtl/rdl_store.sv
module rdl_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // The array has no reset; only its output register is cleared.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rdl_fill.sv
module rdl_fill #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic full
);
  import rdl_pkg::*;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= CW'(fill_next(32'(cnt), DEPTH));
  end

  assign full = (cnt == CW'(DEPTH));
endmodule

// File: rtl/ring_delay_line.sv
module ring_delay_line #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             valid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Internal events, named for the checker.
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          step;

  assign step = en;

  rdl_ptr #(.DEPTH(DEPTH), .AW(AW), .START(DEPTH - 1)) u_wr_ptr (
    .clk(clk), .rst(rst), .adv(step), .addr(wr_addr)
  );

  rdl_ptr #(.DEPTH(DEPTH), .AW(AW), .START(0)) u_rd_ptr (
    .clk(clk), .rst(rst), .adv(step), .addr(rd_addr)
  );

  rdl_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .we(step), .waddr(wr_addr), .wdata(din),
    .re(step), .raddr(rd_addr), .rdata(dout)
  );

  rdl_fill #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst(rst), .adv(step), .full(valid)
  );
endmodule

// File: rtl/ring_delay_line_chk.sv
module ring_delay_line_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] dout,
  input logic             valid,
  input logic [AW-1:0]    wr_addr,
  input logic [AW-1:0]    rd_addr
);
  logic [AW-1:0] wr_succ;
  assign wr_succ = (wr_addr == AW'(DEPTH - 1)) ? '0 : wr_addr + AW'(1);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!valid && dout == '0));

  // R5
  p_reset_addr_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_addr == '0 && wr_addr == AW'(DEPTH - 1)));

  // R5
  p_addr_apart_r5: assert property (@(posedge clk) disable iff (rst)
    rd_addr != wr_addr);

  // R5
  p_read_leads_r5: assert property (@(posedge clk) disable iff (rst)
    rd_addr == wr_succ);

  // R5
  p_rd_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (en && rd_addr == AW'(DEPTH - 1)) |=> rd_addr == '0);

  // R3
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(valid) && $stable(rd_addr)));

  // R4
  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);
endmodule

bind ring_delay_line ring_delay_line_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .dout(dout), .valid(valid),
  .wr_addr(wr_addr), .rd_addr(rd_addr)
);

// File: tb/ring_delay_line_test.sv
module ring_delay_line_test;
  localparam int DEPTH = 5;
  localparam int WIDTH = 8;
  localparam int NVEC  = 24;

  // Each entry: {en, din}.
  localparam logic [8:0] VEC [NVEC] = '{
    9'h111, 9'h122, 9'h033, 9'h133, 9'h144, 9'h155, 9'h0FF, 9'h0EE,
    9'h166, 9'h177, 9'h188, 9'h000, 9'h199, 9'h1AA, 9'h1BB, 9'h0CC,
    9'h1CC, 9'h1DD, 9'h1EE, 9'h1F0, 9'h101, 9'h002, 9'h102, 9'h1FF
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             valid;

  always #4 clk = ~clk;

  ring_delay_line #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout), .valid(valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [WIDTH-1:0] hist [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input logic e, input logic [WIDTH-1:0] d, input string rq);
    en  = e;
    din = d;
    @(posedge clk);
    if (e) hist.push_back(d);
    @(negedge clk);
    check({rq, " valid"}, 32'(valid), 32'(hist.size() >= DEPTH));
    if (hist.size() >= DEPTH)
      check({rq, " data"}, 32'(dout), 32'(hist[hist.size() - DEPTH]));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R2 run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 valid after reset", 32'(valid), 32'd0);
    check("R1 dout after reset", 32'(dout), 32'd0);

    // Table walk: stalls before, during and after filling (R2 data, R3 stalls).
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][8], VEC[i][7:0], VEC[i][8] ? "R2" : "R3");

    // Long run: many passes round the array (R5 wrap).
    for (int i = 0; i < 6 * DEPTH + 3; i++)
      step(1'b1, WIDTH'(i * 37 + 5), "R5");

    // Stall burst while full (R3).
    for (int i = 0; i < 3; i++)
      step(1'b0, WIDTH'(8'hA5 + i), "R3");
    step(1'b1, 8'h3C, "R3");

    // Mid-stream reset (R6).
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    din = 8'h77;
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    hist.delete();
    check("R6 valid after mid reset", 32'(valid), 32'd0);
    check("R6 dout after mid reset", 32'(dout), 32'd0);

    // Refill: valid must rise on exactly the DEPTH-th enabled edge (R4).
    for (int i = 0; i < DEPTH + 2; i++)
      step(1'b1, WIDTH'(8'h90 + i), "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule